// File: doc/BRIEF.md
# Station Address Table and Receive Filter

This block keeps a table of sixteen 48-bit station addresses, each with one enable bit in a 16-bit mask. For each incoming frame it decides whether the destination address is wanted and reports whether the frame was taken as broadcast or as multicast. A small set of mode inputs sets the acceptance rules. The rules are checked in a fixed order: unicast frames under promiscuous mode come first, then any group frame under all-multicast mode, then the all-ones address under broadcast mode, and last an exact match against an enabled table entry.

The table is filled by a counted walk over descriptors in memory. The block issues a fetch request with a byte address. A word source, which stands in for the bus master, answers each request with four 16-bit words. Each descriptor fills one entry. After the last entry, one further descriptor supplies the enable mask. While the controller is held in reset, a host can read any entry back through three 16-bit address ports, selected by an entry pointer.

Top module: `addr_match_unit`

## Requirements
- R1: After reset, loadBusy, loadDone, fetchReq and all rx outputs are 0, every table entry reads as zero, and the enable mask is zero, so a frame with all modes off is rejected.
- R2: rxValid is high exactly in the cycle after a cycle with dstValid high, and low at all other times. rxAccept, rxBcast and rxMcast belong to that same cycle.
- R3: With promiscEn set, a destination whose first byte (dstAddr[7:0]) has bit 0 clear is accepted with no class flag. Promiscuous mode alone does not accept a group frame.
- R4: With allMultiEn set, a destination whose first byte has bit 0 set is accepted with rxMcast set. This rule ranks above broadcast, so an all-ones address then reports rxMcast and not rxBcast. The two flags are never high together.
- R5: With bcastEn set, and the all-multicast rule not applying, the all-ones destination is accepted with rxBcast set.
- R6: A destination equal to table entry i is accepted with no class flag if mask bit i is set. It gets no match from that entry if mask bit i is clear.
- R7: When no rule applies, rxAccept, rxBcast and rxMcast are all 0.
- R8: A load starts on loadStart while idle and fetches descriptors at loadPtrInit, advancing by 8 bytes per entry, or by 16 when wideBus is 1. Entry fetches continue while the low 5 bits of the remaining count are nonzero, and the count drops by one per entry. Count bits above bit 4 are ignored. loadStart is ignored while a load is in progress.
- R9: In an entry descriptor, word 0 is ignored. Words 1, 2 and 3 supply address bytes 0-1, 2-3 and 4-5, the low byte of each word being the even byte. Entries are written from index 0 upward.
- R10: After the last entry one more descriptor is fetched, and its word 0 becomes the enable mask (bit i enables entry i). With a count whose low 5 bits are zero, only this mask descriptor is fetched.
- R11: When the mask descriptor's fourth word is taken, loadBusy falls and loadDone rises in the same cycle. loadDone stays high until the next load starts.
- R12: With inReset high, portData for portSel 0, 1 and 2 returns {byte 2k+1, byte 2k} of the entry chosen by entryPtr[3:0]. It returns 0 when inReset is low or portSel is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loadStart | input | 1 | Start a table load |
| wideBus | input | 1 | 32-bit data width mode (16-byte descriptor step) |
| loadPtrInit | input | 16 | Byte address of the first descriptor |
| loadCountInit | input | 16 | Entry count; low 5 bits used |
| fetchReq | output | 1 | One-cycle request for a descriptor |
| fetchAddr | output | 16 | Byte address of the requested descriptor |
| wordValid | input | 1 | Descriptor word present on wordData |
| wordData | input | 16 | Descriptor word, four per request in order |
| loadBusy | output | 1 | Load command in progress |
| loadDone | output | 1 | Load finished (sticky until next load) |
| inReset | input | 1 | Controller is in reset mode; opens the address ports |
| entryPtr | input | 16 | Entry pointer; low 4 bits select the entry |
| portSel | input | 2 | Address port select (0: bytes 1:0, 1: bytes 3:2, 2: bytes 5:4) |
| portData | output | 16 | Address port read data |
| promiscEn | input | 1 | Promiscuous mode |
| allMultiEn | input | 1 | Accept-all-multicast mode |
| bcastEn | input | 1 | Broadcast-accept mode |
| dstValid | input | 1 | Destination address strobe |
| dstAddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| rxValid | output | 1 | Filter result valid |
| rxAccept | output | 1 | Frame accepted |
| rxBcast | output | 1 | Accepted as broadcast |
| rxMcast | output | 1 | Accepted as multicast |

## Verification
The bench sends an all-ones destination with both all-multicast and broadcast modes on. A filter with the priority reversed would raise rxBcast in place of rxMcast. It loads with a count whose upper bits are set and with a count whose low five bits are zero. A sequencer that tested the whole count would walk far too many descriptors, and one that skipped the mask-only case would fetch entry descriptors that were not asked for. It also reads every port of several entries, inside and outside reset, with an entry pointer whose upper bits are set. A swapped byte order, an off-by-one word slot (word 0 taken as address) or an open port outside reset would each show up as a wrong portData value. Finally, it disables an entry that was loaded earlier, which catches a match array that ignores the enable mask.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int unsigned TBL_DEPTH   = 16;
  localparam int unsigned TBL_IDX_W   = $clog2(TBL_DEPTH);
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned MAC_W       = 48;
  localparam int unsigned ADDR_W      = 16;
  localparam int unsigned CNT_W       = 16;
  localparam int unsigned CNT_LIVE_W  = 5;
  localparam int unsigned DESC_WORDS  = 4;
  localparam int unsigned SLOT_W      = $clog2(DESC_WORDS);
  localparam int unsigned PORT_COUNT  = MAC_W / WORD_W;
  localparam int unsigned PSEL_W      = $clog2(PORT_COUNT + 1);
  localparam int unsigned NARROW_STEP = DESC_WORDS * 2;
  localparam int unsigned WIDE_STEP   = DESC_WORDS * 4;

  // Strobes from the load sequencer to the table datapath
  typedef struct packed {
    logic                 wr;
    logic                 isMask;
    logic [SLOT_W-1:0]    slot;
    logic [TBL_IDX_W-1:0] idx;
  } tbl_strobe_t;
endpackage

// File: rtl/addr_match_ctrl.sv
module addr_match_ctrl
  import addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadStart,
  input  logic              wideBus,
  input  logic [ADDR_W-1:0] loadPtrInit,
  input  logic [CNT_W-1:0]  loadCountInit,
  input  logic              wordValid,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              loadBusy,
  output logic              loadDone,
  output tbl_strobe_t       strobe
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WORDS} load_state_t;

  load_state_t          state;
  logic [ADDR_W-1:0]    descPtr;
  logic [CNT_W-1:0]     remaining;
  logic [TBL_IDX_W-1:0] entryIdx;
  logic [SLOT_W-1:0]    slot;
  logic                 maskPhase;
  logic                 doneFlag;
  logic [CNT_W-1:0]     remainingNext;
  logic [ADDR_W-1:0]    step;
  logic                 lastWord;

  assign remainingNext = remaining - CNT_W'(1);
  assign step          = wideBus ? ADDR_W'(WIDE_STEP) : ADDR_W'(NARROW_STEP);
  assign lastWord      = wordValid && (slot == SLOT_W'(DESC_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      descPtr   <= '0;
      remaining <= '0;
      entryIdx  <= '0;
      slot      <= '0;
      maskPhase <= 1'b0;
      doneFlag  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (loadStart) begin
          descPtr   <= loadPtrInit;
          remaining <= loadCountInit;
          entryIdx  <= '0;
          slot      <= '0;
          maskPhase <= (loadCountInit[CNT_LIVE_W-1:0] == '0);
          doneFlag  <= 1'b0;
          state     <= S_REQ;
        end
        S_REQ: begin
          slot  <= '0;
          state <= S_WORDS;
        end
        S_WORDS: if (wordValid) begin
          slot <= slot + SLOT_W'(1);
          if (lastWord) begin
            if (maskPhase) begin
              doneFlag <= 1'b1;
              state    <= S_IDLE;
            end else begin
              descPtr   <= descPtr + step;
              remaining <= remainingNext;
              entryIdx  <= entryIdx + TBL_IDX_W'(1);
              maskPhase <= (remainingNext[CNT_LIVE_W-1:0] == '0);
              state     <= S_REQ;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign fetchReq  = (state == S_REQ);
  assign fetchAddr = descPtr;
  assign loadBusy  = (state != S_IDLE);
  assign loadDone  = doneFlag;

  always_comb begin
    strobe.wr     = (state == S_WORDS) && wordValid;
    strobe.isMask = maskPhase;
    strobe.slot   = slot;
    strobe.idx    = entryIdx;
  end
endmodule

// File: rtl/addr_match_dp.sv
module addr_match_dp
  import addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tbl_strobe_t       strobe,
  input  logic [WORD_W-1:0] wordData,
  input  logic              inReset,
  input  logic [WORD_W-1:0] entryPtr,
  input  logic [PSEL_W-1:0] portSel,
  output logic [WORD_W-1:0] portData,
  input  logic              promiscEn,
  input  logic              allMultiEn,
  input  logic              bcastEn,
  input  logic              dstValid,
  input  logic [MAC_W-1:0]  dstAddr,
  output logic              rxValid,
  output logic              rxAccept,
  output logic              rxBcast,
  output logic              rxMcast
);
  logic [MAC_W-1:0]     entryTbl [TBL_DEPTH];
  logic [TBL_DEPTH-1:0] enMask;
  logic [TBL_DEPTH-1:0] hit;
  logic                 isGroup, isAllOnes;
  logic                 accNow, bcNow, mcNow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < TBL_DEPTH; e++) entryTbl[e] <= '0;
      enMask <= '0;
    end else if (strobe.wr) begin
      if (strobe.isMask) begin
        if (strobe.slot == '0) enMask <= wordData[TBL_DEPTH-1:0];
      end else begin
        for (int w = 0; w < PORT_COUNT; w++)
          if (strobe.slot == SLOT_W'(w + 1))
            entryTbl[strobe.idx][w*WORD_W +: WORD_W] <= wordData;
      end
    end
  end

  for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_match
    assign hit[e] = enMask[e] && (entryTbl[e] == dstAddr);
  end

  assign isGroup   = dstAddr[0];
  assign isAllOnes = &dstAddr;

  always_comb begin
    accNow = 1'b0;
    bcNow  = 1'b0;
    mcNow  = 1'b0;
    if (promiscEn && !isGroup) begin
      accNow = 1'b1;
    end else if (allMultiEn && isGroup) begin
      accNow = 1'b1;
      mcNow  = 1'b1;
    end else if (bcastEn && isAllOnes) begin
      accNow = 1'b1;
      bcNow  = 1'b1;
    end else if (|hit) begin
      accNow = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxValid  <= 1'b0;
      rxAccept <= 1'b0;
      rxBcast  <= 1'b0;
      rxMcast  <= 1'b0;
    end else begin
      rxValid  <= dstValid;
      rxAccept <= dstValid && accNow;
      rxBcast  <= dstValid && bcNow;
      rxMcast  <= dstValid && mcNow;
    end
  end

  always_comb begin
    portData = '0;
    if (inReset && (int'(portSel) < PORT_COUNT))
      portData = entryTbl[entryPtr[TBL_IDX_W-1:0]][int'(portSel)*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/addr_match_unit.sv
module addr_match_unit
  import addr_match_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadStart,
  input  logic              wideBus,
  input  logic [ADDR_W-1:0] loadPtrInit,
  input  logic [CNT_W-1:0]  loadCountInit,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              loadBusy,
  output logic              loadDone,
  input  logic              inReset,
  input  logic [WORD_W-1:0] entryPtr,
  input  logic [PSEL_W-1:0] portSel,
  output logic [WORD_W-1:0] portData,
  input  logic              promiscEn,
  input  logic              allMultiEn,
  input  logic              bcastEn,
  input  logic              dstValid,
  input  logic [MAC_W-1:0]  dstAddr,
  output logic              rxValid,
  output logic              rxAccept,
  output logic              rxBcast,
  output logic              rxMcast
);
  tbl_strobe_t strobe;

  addr_match_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .loadStart(loadStart), .wideBus(wideBus),
    .loadPtrInit(loadPtrInit), .loadCountInit(loadCountInit),
    .wordValid(wordValid), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .loadBusy(loadBusy), .loadDone(loadDone), .strobe(strobe)
  );

  addr_match_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wordData(wordData),
    .inReset(inReset), .entryPtr(entryPtr), .portSel(portSel),
    .portData(portData), .promiscEn(promiscEn), .allMultiEn(allMultiEn),
    .bcastEn(bcastEn), .dstValid(dstValid), .dstAddr(dstAddr),
    .rxValid(rxValid), .rxAccept(rxAccept), .rxBcast(rxBcast),
    .rxMcast(rxMcast)
  );
endmodule

// File: rtl/addr_match_chk.sv
module addr_match_chk
  import addr_match_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fetchReq,
  input logic              loadBusy,
  input logic              loadDone,
  input logic              inReset,
  input logic [WORD_W-1:0] portData,
  input logic              dstValid,
  input logic              rxValid,
  input logic              rxAccept,
  input logic              rxBcast,
  input logic              rxMcast
);
  // R2
  rx_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dstValid |=> rxValid);
  // R2
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dstValid |=> !rxValid);
  // R7
  flags_need_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxBcast || rxMcast) |-> rxAccept);
  // R4
  one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rxBcast && rxMcast));
  // R11
  done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loadDone) |-> $fell(loadBusy));
  // R8
  fetch_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq |-> loadBusy);
  // R8
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq |=> !fetchReq);
  // R12
  port_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inReset |-> (portData == '0));
endmodule

bind addr_match_unit addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fetchReq(fetchReq), .loadBusy(loadBusy),
  .loadDone(loadDone), .inReset(inReset), .portData(portData),
  .dstValid(dstValid), .rxValid(rxValid), .rxAccept(rxAccept),
  .rxBcast(rxBcast), .rxMcast(rxMcast)
);

// File: tb/addr_match_unit_test.sv
module addr_match_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadStart = 1'b0, wideBus = 1'b0;
  logic [15:0] loadPtrInit = '0, loadCountInit = '0;
  logic        fetchReq;
  logic [15:0] fetchAddr;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic        loadBusy, loadDone;
  logic        inReset = 1'b0;
  logic [15:0] entryPtr = '0;
  logic [1:0]  portSel = '0;
  logic [15:0] portData;
  logic        promiscEn = 1'b0, allMultiEn = 1'b0, bcastEn = 1'b0;
  logic        dstValid = 1'b0;
  logic [47:0] dstAddr = '0;
  logic        rxValid, rxAccept, rxBcast, rxMcast;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_match_unit uut (
    .clk(clk), .rst_n(rst_n), .loadStart(loadStart), .wideBus(wideBus),
    .loadPtrInit(loadPtrInit), .loadCountInit(loadCountInit),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .wordValid(wordValid),
    .wordData(wordData), .loadBusy(loadBusy), .loadDone(loadDone),
    .inReset(inReset), .entryPtr(entryPtr), .portSel(portSel),
    .portData(portData), .promiscEn(promiscEn), .allMultiEn(allMultiEn),
    .bcastEn(bcastEn), .dstValid(dstValid), .dstAddr(dstAddr),
    .rxValid(rxValid), .rxAccept(rxAccept), .rxBcast(rxBcast),
    .rxMcast(rxMcast)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Memory model: content of word k of the descriptor at byte address a
  function automatic logic [15:0] memWord(input logic [15:0] a, input int k);
    return (a * 16'd19) ^ (16'h1111 * 16'(k)) ^ 16'h4200;
  endfunction

  function automatic logic [47:0] entryAt(input logic [15:0] a);
    return {memWord(a, 3), memWord(a, 2), memWord(a, 1)};
  endfunction

  // R8 R9 R10 R11: start a load and serve every descriptor it requests
  task automatic runLoad(input logic [15:0] ptr, input logic [15:0] cnt,
                         input logic wide, input logic [15:0] mask);
    int nEntries = int'(cnt[4:0]);
    int step = wide ? 16 : 8;
    @(negedge clk);
    wideBus = wide; loadPtrInit = ptr; loadCountInit = cnt; loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0;
    for (int n = 0; n <= nEntries; n++) begin
      logic [15:0] a = ptr + 16'(n * step);
      while (!fetchReq) @(negedge clk);
      chk(n < nEntries ? "R8 entry fetch address" : "R10 mask fetch address", fetchAddr, a);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        wordValid = 1'b1;
        wordData = (n == nEntries && k == 0) ? mask : memWord(a, k);
      end
      @(negedge clk);
      wordValid = 1'b0;
    end
    chk("R11 busy clear after load", loadBusy, 0);
    chk("R11 done set after load", loadDone, 1);
    chk("R10 no extra fetch", fetchReq, 0);
  endtask

  task automatic sendDst(input string req, input logic [47:0] d,
                         input logic expAcc, input logic expB, input logic expM);
    @(negedge clk);
    dstValid = 1'b1; dstAddr = d;
    @(negedge clk);
    dstValid = 1'b0;
    chk({req, " valid"}, rxValid, 1);
    chk({req, " accept"}, rxAccept, expAcc);
    chk({req, " bcast flag"}, rxBcast, expB);
    chk({req, " mcast flag"}, rxMcast, expM);
    @(negedge clk);
    chk("R2 valid lasts one cycle", rxValid, 0);
  endtask

  task automatic testReset();
    chk("R1 busy", loadBusy, 0);
    chk("R1 done", loadDone, 0);
    chk("R1 fetchReq", fetchReq, 0);
    chk("R1 rxValid", rxValid, 0);
    inReset = 1'b1; entryPtr = 16'h0003; portSel = 2'd1;
    #1 chk("R1 entry reads zero", portData, 0);
    inReset = 1'b0;
    sendDst("R1 R7 reject with modes off", 48'h0000_0000_0000, 0, 0, 0);
  endtask

  task automatic testPorts(input logic [15:0] ptr, input int step, input int n);
    inReset = 1'b1;
    for (int e = 0; e < n; e++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        entryPtr = 16'(e) | 16'hABC0; portSel = 2'(p);
        #1 chk("R12 R9 port read", portData,
               p < 3 ? memWord(ptr + 16'(e * step), p + 1) : 16'h0);
      end
    end
    @(negedge clk);
    inReset = 1'b0; entryPtr = 16'h0000; portSel = 2'd0;
    #1 chk("R12 port closed outside reset", portData, 0);
  endtask

  task automatic testModes();
    sendDst("R3 promiscuous unicast", 48'h0000_1234_5678, 0, 0, 0);
    promiscEn = 1'b1;
    sendDst("R3 promiscuous unicast", 48'h0000_1234_5678, 1, 0, 0);
    sendDst("R3 promiscuous skips group", 48'h0000_1234_5601, 0, 0, 0);
    promiscEn = 1'b0; allMultiEn = 1'b1;
    sendDst("R4 all-multicast group", 48'h0000_1234_5601, 1, 0, 1);
    bcastEn = 1'b1;
    sendDst("R4 multicast ranks over broadcast", 48'hFFFF_FFFF_FFFF, 1, 0, 1);
    allMultiEn = 1'b0;
    sendDst("R5 broadcast", 48'hFFFF_FFFF_FFFF, 1, 1, 0);
    sendDst("R5 R7 non-broadcast group", 48'hFFFF_FFFF_FF01, 0, 0, 0);
    bcastEn = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    // Narrow load: 3 entries (upper count bits ignored), mask enables 0 and 2
    runLoad(16'h0100, 16'hFFE3, 1'b0, 16'h0005);
    testPorts(16'h0100, 8, 3);
    sendDst("R6 enabled entry 0", entryAt(16'h0100), 1, 0, 0);
    sendDst("R6 enabled entry 2", entryAt(16'h0110), 1, 0, 0);
    sendDst("R6 disabled entry 1", entryAt(16'h0108), 0, 0, 0);
    testModes();
    // Wide load: 2 entries with 16-byte step, mask enables entry 1
    runLoad(16'h0400, 16'h0002, 1'b1, 16'h0002);
    testPorts(16'h0400, 16, 2);
    sendDst("R6 wide entry 1", entryAt(16'h0410), 1, 0, 0);
    sendDst("R6 entry 2 now disabled", entryAt(16'h0110), 0, 0, 0);
    // Count with low bits zero: only the mask descriptor, mask cleared
    runLoad(16'h0800, 16'h0020, 1'b1, 16'h0000);
    sendDst("R10 mask cleared", entryAt(16'h0410), 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule